// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the sixteen-entry general register file of a processor core whose privileged modes keep private copies of some registers. Software addresses registers by architectural index 0 to 15. The current processor mode, together with that index, chooses which physical copy is read or written. The fast-interrupt mode owns private copies of indices 8 to 14, so its handler has scratch registers of its own. The normal-interrupt, supervisor, abort and undefined-instruction modes each own only a private stack pointer (index 13) and link register (index 14). User mode, and any mode code that is not defined, uses the base set.

The file has two combinational read ports and one clocked write port, all addressed by architectural index under the current mode. A second write port, the entry link port, serves the exception controller. It writes the link register (index 14) of a named target mode, whatever mode is current. Index 15 is not stored: its reads return the program-counter value supplied from outside.

Top module: `bank_regfile`

## Requirements
- R1: After reset every stored register reads as zero in every mode.
- R2: Indices 0 to 7 name one shared physical copy in all modes.
- R3: In fast mode (mode code 1), indices 8 to 14 select private copies. Writes to them in fast mode leave the values seen by every other mode unchanged, and writes from other modes leave the fast copies unchanged.
- R4: In normal-interrupt mode (mode code 2), indices 8 to 12 use the shared copies, while indices 13 and 14 are private to that mode.
- R5: Supervisor (mode code 3), abort (mode code 4) and undefined-instruction (mode code 5) modes each have their own private copies of indices 13 and 14.
- R6: User mode (mode code 0) uses the base set, and mode codes 6 and 7 select the same physical registers as user mode.
- R7: When a read port addresses the physical register that is being written in the same cycle, it returns the new value.
- R8: A read of index 15 on either port returns `pc_i`, and a write to index 15 changes no stored register.
- R9: A write on the entry link port updates the index-14 copy of `lnk_mode`, independent of `mode_i`.
- R10: When both write ports target the same physical register in one cycle, the entry link port's value is the one stored and bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Current processor mode code |
| pc_i | input | DATA_W | Value returned for index 15 |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write architectural index |
| wr_data | input | DATA_W | General write data |
| lnk_en | input | 1 | Entry link write enable |
| lnk_mode | input | 3 | Mode whose index-14 copy the link port writes |
| lnk_data | input | DATA_W | Entry link write data |

## Verification
The bench writes a tag encoding mode and index into every index under each of the eight mode codes in turn. It then reads every index back under every mode code and compares with a model that only knows which mode pairs share each index. Any index that is banked where it should be shared, or shared where it should be banked, shows up as a value carrying the wrong mode tag. Same-cycle read-during-write patterns separate write-first from read-old behaviour. Link-port writes issued from user mode toward each target mode separate target-mode from current-mode selection, and a simultaneous collision on one physical register shows which port wins. Writes to index 15 followed by a full readback show that the PC slot holds nothing.

// File: rtl/bank_pkg.sv
package bank_pkg;

  localparam int AIDX_W     = 4;
  localparam int SHARED_N   = 13;
  localparam int PAIR_GRPS  = 5;
  localparam int FAST_N     = 7;
  localparam int PAIR_BASE  = SHARED_N;
  localparam int FAST_BASE  = PAIR_BASE + 2 * PAIR_GRPS;
  localparam int NPHYS      = FAST_BASE + FAST_N;
  localparam int PHYS_W     = $clog2(NPHYS);

  localparam logic [2:0] MODE_USER  = 3'd0;
  localparam logic [2:0] MODE_FAST  = 3'd1;
  localparam logic [2:0] MODE_IRQ   = 3'd2;
  localparam logic [2:0] MODE_SUPV  = 3'd3;
  localparam logic [2:0] MODE_ABORT = 3'd4;
  localparam logic [2:0] MODE_UNDEF = 3'd5;

  localparam logic [AIDX_W-1:0] IDX_LINK = 4'd14;
  localparam logic [AIDX_W-1:0] IDX_PC   = 4'd15;

  // Undefined codes fall back to the user set.
  function automatic logic [2:0] norm_mode(input logic [2:0] m);
    return (m > MODE_UNDEF) ? MODE_USER : m;
  endfunction

  // Which stack/link pair a mode owns (0 = user pair).
  function automatic int pair_group(input logic [2:0] m);
    case (norm_mode(m))
      MODE_IRQ:   return 1;
      MODE_SUPV:  return 2;
      MODE_ABORT: return 3;
      MODE_UNDEF: return 4;
      default:    return 0;
    endcase
  endfunction

  // Physical slot for (mode, index); meaningless for index 15.
  function automatic logic [PHYS_W-1:0] phys_of(input logic [2:0] m,
                                                  input logic [AIDX_W-1:0] idx);
    int n;
    if (idx < 4'd8)
      n = int'(idx);
    else if (norm_mode(m) == MODE_FAST && idx != IDX_PC)
      n = FAST_BASE + int'(idx) - 8;
    else if (idx < 4'd13)
      n = int'(idx);
    else
      n = PAIR_BASE + 2 * pair_group(m) + (int'(idx) - 13);
    if (n >= NPHYS) n = 0;
    return PHYS_W'(n);
  endfunction

endpackage

// File: rtl/bank_map.sv
module bank_map
  import bank_pkg::*;
(
  input  logic [2:0]        mode,
  input  logic [AIDX_W-1:0] idx,
  output logic [PHYS_W-1:0] phys,
  output logic              is_pc
);
  always_comb begin
    phys  = phys_of(mode, idx);
    is_pc = (idx == IDX_PC);
  end
endmodule

// File: rtl/bank_storage.sv
module bank_storage
  import bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS  = NPHYS,
  parameter int RPORTS = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we_g,
  input  logic [PHYS_W-1:0]              wa_g,
  input  logic [DATA_W-1:0]              wd_g,
  input  logic                           we_l,
  input  logic [PHYS_W-1:0]              wa_l,
  input  logic [DATA_W-1:0]              wd_l,
  input  logic [RPORTS-1:0][PHYS_W-1:0]  ra,
  output logic [RPORTS-1:0][DATA_W-1:0]  rd
);
  logic [DATA_W-1:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      // Link port is applied last so it wins a collision.
      if (we_g) regs[wa_g] <= wd_g;
      if (we_l) regs[wa_l] <= wd_l;
    end
  end

  for (genvar p = 0; p < RPORTS; p++) begin : g_rport
    always_comb begin
      if (we_l && wa_l == ra[p])
        rd[p] = wd_l;
      else if (we_g && wa_g == ra[p])
        rd[p] = wd_g;
      else
        rd[p] = regs[ra[p]];
    end
  end
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lnk_en,
  input  logic [2:0]        lnk_mode,
  input  logic [DATA_W-1:0] lnk_data
);
  localparam int RPORTS = 2;

  logic [PHYS_W-1:0] rd_a_phys, rd_b_phys, wr_phys, lnk_phys;
  logic              rd_a_pc, rd_b_pc, wr_pc, lnk_pc_unused;
  logic              wr_fire;
  logic [RPORTS-1:0][PHYS_W-1:0] ra;
  logic [RPORTS-1:0][DATA_W-1:0] rd;

  bank_map u_map_a   (.mode(mode_i),   .idx(rd_a_idx), .phys(rd_a_phys), .is_pc(rd_a_pc));
  bank_map u_map_b   (.mode(mode_i),   .idx(rd_b_idx), .phys(rd_b_phys), .is_pc(rd_b_pc));
  bank_map u_map_w   (.mode(mode_i),   .idx(wr_idx),   .phys(wr_phys),   .is_pc(wr_pc));
  bank_map u_map_lnk (.mode(lnk_mode), .idx(IDX_LINK), .phys(lnk_phys),  .is_pc(lnk_pc_unused));

  assign wr_fire = wr_en && !wr_pc;
  assign ra[0]   = rd_a_phys;
  assign ra[1]   = rd_b_phys;

  bank_storage #(.DATA_W(DATA_W), .NREGS(NPHYS), .RPORTS(RPORTS)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we_g (wr_fire),
    .wa_g (wr_phys),
    .wd_g (wr_data),
    .we_l (lnk_en),
    .wa_l (lnk_phys),
    .wd_l (lnk_data),
    .ra   (ra),
    .rd   (rd)
  );

  assign rd_a_data = rd_a_pc ? pc_i : rd[0];
  assign rd_b_data = rd_b_pc ? pc_i : rd[1];
endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk
  import bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_i,
  input logic [DATA_W-1:0] pc_i,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [3:0]        rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              lnk_en,
  input logic [DATA_W-1:0] lnk_data,
  input logic [PHYS_W-1:0] rd_a_phys,
  input logic [PHYS_W-1:0] wr_phys,
  input logic [PHYS_W-1:0] lnk_phys
);
  logic wr_live;
  assign wr_live = wr_en && wr_idx != IDX_PC;

  p_pc_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == IDX_PC) |-> (rd_a_data == pc_i));

  p_pc_read_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == IDX_PC) |-> (rd_b_data == pc_i));

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_live && rd_a_idx != IDX_PC && wr_phys == rd_a_phys &&
     !(lnk_en && lnk_phys == wr_phys)) |-> (rd_a_data == wr_data));

  p_link_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_en && rd_a_idx != IDX_PC && lnk_phys == rd_a_phys) |-> (rd_a_data == lnk_data));

  p_fast_private_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_mode(mode_i) == MODE_FAST && wr_live && wr_idx >= 4'd8) |->
      (int'(wr_phys) >= FAST_BASE));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_live && !(lnk_en && lnk_phys == wr_phys)) |=>
      ((rd_a_idx != IDX_PC && rd_a_phys == $past(wr_phys) && !wr_en && !lnk_en)
        ? (rd_a_data == $past(wr_data)) : 1'b1));
endmodule

bind bank_regfile bank_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pc_i(pc_i),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .lnk_en(lnk_en), .lnk_data(lnk_data),
  .rd_a_phys(rd_a_phys), .wr_phys(wr_phys), .lnk_phys(lnk_phys)
);

// File: tb/bank_regfile_tb.sv
module bank_regfile_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  mode_i = 0;
  logic [31:0] pc_i = 32'hC0DE_0F00;
  logic [3:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0, lnk_data = 0;
  logic        wr_en = 0, lnk_en = 0;
  logic [2:0]  lnk_mode = 0;

  int errors = 0, checks = 0;
  logic [31:0] model [8][15];

  always #10 clk = ~clk;

  bank_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pc_i(pc_i),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .lnk_en(lnk_en), .lnk_mode(lnk_mode), .lnk_data(lnk_data)
  );

  // Do modes m1 and m2 see the same copy of index idx?
  function automatic bit shares(int m1, int m2, int idx);
    int a = (m1 > 5) ? 0 : m1;
    int b = (m2 > 5) ? 0 : m2;
    if (idx < 8)  return 1;
    if (idx < 13) return (a == 1) == (b == 1);
    return a == b;
  endfunction

  function automatic logic [31:0] tag(int m, int idx, int salt);
    return 32'hA000_0000 | (salt << 16) | (m << 8) | idx;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(int m, int idx, logic [31:0] v);
    for (int k = 0; k < 8; k++) if (shares(k, m, idx)) model[k][idx] = v;
  endtask

  task automatic gp_write(int m, int idx, logic [31:0] v);
    @(negedge clk);
    mode_i = 3'(m); wr_en = 1; wr_idx = 4'(idx); wr_data = v;
    @(negedge clk);
    wr_en = 0;
    if (idx != 15) model_write(m, idx, v);
  endtask

  task automatic read_all(string req);
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        mode_i = 3'(m); rd_a_idx = 4'(i); rd_b_idx = 4'(14 - i);
        #1;
        check(req, rd_a_data, model[m][i]);
        check(req, rd_b_data, model[m][14 - i]);
      end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int m = 0; m < 8; m++) for (int i = 0; i < 15; i++) model[m][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    read_all("R1 reset zero");

    // R2 R3 R4 R5 R6: tag every index from every mode, then read back
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 15; i++) gp_write(m, i, tag(m, i, 1));
    read_all("R2/R3/R4/R5/R6 banking");

    // R3: fast-mode writes to 8..12 then user readback of same
    for (int i = 8; i < 13; i++) gp_write(1, i, tag(1, i, 2));
    read_all("R3 fast isolation");

    // R8: index 15 reads pc, writes to 15 ignored
    for (int m = 0; m < 8; m++) gp_write(m, 15, 32'hDEAD_BEEF);
    read_all("R8 pc write ignored");
    @(negedge clk);
    rd_a_idx = 15; rd_b_idx = 15; pc_i = 32'h1234_5678; #1;
    check("R8 pc read A", rd_a_data, 32'h1234_5678);
    check("R8 pc read B", rd_b_data, 32'h1234_5678);

    // R7: same-cycle bypass on both ports, several modes
    for (int m = 0; m < 6; m++) begin
      @(negedge clk);
      mode_i = 3'(m); wr_en = 1; wr_idx = 13; wr_data = tag(m, 13, 3);
      rd_a_idx = 13; rd_b_idx = 13; #1;
      check("R7 bypass A", rd_a_data, tag(m, 13, 3));
      check("R7 bypass B", rd_b_data, tag(m, 13, 3));
      @(negedge clk); wr_en = 0;
      model_write(m, 13, tag(m, 13, 3));
    end

    // R9: link port from user mode into each target mode
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      mode_i = 0; lnk_en = 1; lnk_mode = 3'(t); lnk_data = tag(t, 14, 4);
      @(negedge clk); lnk_en = 0;
      model_write(t, 14, tag(t, 14, 4));
    end
    read_all("R9 link target mode");

    // R10: collision, both ports on IRQ r14
    @(negedge clk);
    mode_i = 2; wr_en = 1; wr_idx = 14; wr_data = 32'h1111_1111;
    lnk_en = 1; lnk_mode = 2; lnk_data = 32'h2222_2222; rd_a_idx = 14; #1;
    check("R10 collision bypass", rd_a_data, 32'h2222_2222);
    @(negedge clk); wr_en = 0; lnk_en = 0; #1;
    check("R10 collision stored", rd_a_data, 32'h2222_2222);
    model_write(2, 14, 32'h2222_2222);
    read_all("R10 after collision");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule